// File: doc/BRIEF.md
# Edge-Detecting Bidirectional GPIO Port

This block is a general-purpose I/O port with a parameterised number of pins (eight by default). Each pin can be switched between input and output, and each pin has its own edge detector. A detector watches either falling or rising transitions, chosen per pin, and records a detection in a sticky flag that software later clears.

Software reaches the port through a small synchronous register interface: a two-bit address, a write strobe with write data, and a registered read bus that always shows the register selected by the address of the previous cycle. Pin inputs are brought into the clock domain by a two-stage synchronizer before they are sampled or compared. Pin outputs and output enables come straight from flops.

Top module: `gpio_edge_port`

## Requirements
- R1: While reset is high, and after its release, the direction, polarity, flag and data registers read 0, pin_oe is 0 and pin_out is 0, so every pin is an input watching for falling edges.
- R2: The register at address 0 is data, 1 is direction, 2 is polarity, 3 is edge flags; reg_rdata shows, one clock later, the register selected by reg_addr.
- R3: Writing the direction register sets pin_oe to the written value on the next clock; a 1 bit makes that pin an output.
- R4: Writing the data register stores the value and drives it on pin_out on the next clock, whatever the direction of each pin.
- R5: Reading the data register returns, for input pins, the pin level after the two-stage synchronizer, and for output pins the stored data bit.
- R6: With polarity bit 0, a high-to-low change on a pin sets its flag; a low-to-high change does not.
- R7: With polarity bit 1, a low-to-high change on a pin sets its flag; a high-to-low change does not.
- R8: A set flag stays set while further pin changes of either direction occur and no clearing write reaches it.
- R9: Writing 0 to a flag bit clears it; writing 1 to a flag bit leaves it unchanged.
- R10: A detected edge in the same cycle as a write that clears its flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | NPINS | Write data |
| reg_rdata | output | NPINS | Registered read data |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Values driven to the pads |
| pin_oe | output | NPINS | Per-pin output enable |

## Verification
The bench aims at the collision of a detected edge with a clearing write in the same clock; a design that gives the write priority would lose that edge. It checks that writing ones to the flag register does nothing, which a design treating the write as a plain store would break by setting flags. Edges in the unwatched direction are applied to catch an inverted polarity decode, and data reads on mixed-direction ports catch a design that returns the stored value for inputs or the pin level for outputs. Random pin patterns with changing polarity and partial clears exercise stickiness across many pins at once.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_POL  = 2'd2,
    SEL_FLAG = 2'd3
  } gpio_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_edge_cell.sv
module gpio_edge_cell (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic rising_sel,
  input  logic clear,
  output logic flag
);
  logic level_d;
  logic hit;

  always_ff @(posedge clk) begin
    if (rst) level_d <= 1'b0;
    else     level_d <= level;
  end

  // a transition toward the watched level
  always_comb begin
    hit = (level != level_d) && (level == rising_sel);
  end

  // detection wins over a clearing write
  always_ff @(posedge clk) begin
    if (rst)        flag <= 1'b0;
    else if (hit)   flag <= 1'b1;
    else if (clear) flag <= 1'b0;
  end
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_edge_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [NPINS-1:0]  reg_wdata,
  input  logic [NPINS-1:0]  pin_level,
  input  logic [NPINS-1:0]  flags,
  output logic [NPINS-1:0]  data_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  pol_q,
  output logic [NPINS-1:0]  flag_clr,
  output logic [NPINS-1:0]  rdata_q
);
  gpio_sel_e        sel;
  logic [NPINS-1:0] rd_mux;

  assign sel = gpio_sel_e'(reg_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
      pol_q  <= '0;
    end else if (reg_wr) begin
      case (sel)
        SEL_DATA: data_q <= reg_wdata;
        SEL_DIR:  dir_q  <= reg_wdata;
        SEL_POL:  pol_q  <= reg_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    flag_clr = '0;
    if (reg_wr && sel == SEL_FLAG) flag_clr = ~reg_wdata;
  end

  always_comb begin
    case (sel)
      SEL_DATA: rd_mux = (pin_level & ~dir_q) | (data_q & dir_q);
      SEL_DIR:  rd_mux = dir_q;
      SEL_POL:  rd_mux = pol_q;
      default:  rd_mux = flags;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [NPINS-1:0]  reg_wdata,
  output logic [NPINS-1:0]  reg_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);
  logic [NPINS-1:0] level_s;
  logic [NPINS-1:0] flag_q;
  logic [NPINS-1:0] flag_clr;
  logic [NPINS-1:0] data_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] pol_q;

  gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(level_s)
  );

  genvar i;
  generate
    for (i = 0; i < NPINS; i++) begin : g_pin
      gpio_edge_cell u_cell (
        .clk(clk), .rst(rst), .level(level_s[i]), .rising_sel(pol_q[i]),
        .clear(flag_clr[i]), .flag(flag_q[i])
      );
    end
  endgenerate

  gpio_reg_bank #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .pin_level(level_s), .flags(flag_q),
    .data_q(data_q), .dir_q(dir_q), .pol_q(pol_q), .flag_clr(flag_clr),
    .rdata_q(reg_rdata)
  );

  assign pin_out = data_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
  import gpio_edge_pkg::*;
#(
  parameter int NPINS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [NPINS-1:0]  reg_wdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NPINS-1:0]  flag_q
);
  logic [NPINS-1:0] keep_mask;
  always_comb begin
    keep_mask = flag_q;
    if (reg_wr && reg_addr == SEL_FLAG) keep_mask = flag_q & reg_wdata;
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (flag_q == '0 && pin_oe == '0 && pin_out == '0));

  p_oe_write_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == SEL_DIR) |=> pin_oe == $past(reg_wdata));

  p_oe_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == SEL_DIR) |=> $stable(pin_oe));

  p_out_write_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == SEL_DATA) |=> pin_out == $past(reg_wdata));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & $past(keep_mask)) == $past(keep_mask)));
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .flag_q(flag_q)
);

// File: tb/sim_gpio_edge_port.sv
module sim_gpio_edge_port;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   reg_addr = 2'd0;
  logic         reg_wr = 1'b0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out;
  logic [N-1:0] pin_oe;

  int n_run = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  gpio_edge_port #(.NPINS(N)) u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // bench model of the port
  logic [N-1:0] m_pins = '0, m_dir = '0, m_pol = '0, m_flag = '0, m_data = '0;

  function automatic logic [N-1:0] edge_hits(input logic [N-1:0] o, input logic [N-1:0] n,
                                             input logic [N-1:0] pol);
    return (o ^ n) & ~(n ^ pol);
  endfunction

  function automatic logic [N-1:0] data_view(input logic [N-1:0] pins, input logic [N-1:0] dir,
                                             input logic [N-1:0] dat);
    return (pins & ~dir) | (dat & dir);
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] v);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #1 v = reg_rdata;
  endtask

  task automatic set_pins(input logic [N-1:0] p);
    @(negedge clk);
    m_flag = m_flag | edge_hits(m_pins, p, m_pol);
    m_pins = p;
    pin_in = p;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    logic [N-1:0] v;
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1;
    check("R1 oe in reset", pin_oe, '0);
    check("R1 out in reset", pin_out, '0);
    @(negedge clk); rst = 1'b0;
    rd(2'd1, v); check("R1 dir after reset", v, '0);
    rd(2'd2, v); check("R1 pol after reset", v, '0);
    rd(2'd3, v); check("R1 flags after reset", v, '0);
    rd(2'd0, v); check("R1 data after reset", v, '0);

    // R2 R3 R4 register map and outputs
    wr(2'd1, 8'hA5); m_dir = 8'hA5;
    #1 check("R3 oe follows dir", pin_oe, 8'hA5);
    wr(2'd0, 8'h3C); m_data = 8'h3C;
    #1 check("R4 out follows data", pin_out, 8'h3C);
    rd(2'd1, v); check("R2 dir readback", v, 8'hA5);
    set_pins(8'hF0);
    rd(2'd0, v); check("R5 mixed data read", v, data_view(m_pins, m_dir, m_data));
    rd(2'd3, v); check("R6 rising in falling mode", v, m_flag);
    wr(2'd1, 8'h00); m_dir = 8'h00;
    rd(2'd0, v); check("R5 all inputs", v, 8'hF0);
    #1 check("R4 out kept with inputs", pin_out, 8'h3C);

    // R6 falling
    set_pins(8'h30);
    rd(2'd3, v); check("R6 falling sets flags", v, 8'hC0);
    // R8 sticky
    set_pins(8'hF0); set_pins(8'h30);
    rd(2'd3, v); check("R8 sticky", v, 8'hC0);
    // R9 write one keeps, zero clears
    wr(2'd3, 8'hFF);
    rd(2'd3, v); check("R9 write ones no effect", v, 8'hC0);
    wr(2'd3, 8'h7F); m_flag = 8'h40;
    rd(2'd3, v); check("R9 clear bit7", v, 8'h40);
    // R7 rising
    wr(2'd2, 8'h0F); m_pol = 8'h0F;
    wr(2'd3, 8'h00); m_flag = '0;
    set_pins(8'h35);
    rd(2'd3, v); check("R7 rising sets", v, 8'h05);
    set_pins(8'h30);
    rd(2'd3, v); check("R7 falling ignored in rising mode", v, 8'h05);

    // R10 edge during clearing write; pin 0 flag already set
    @(negedge clk); pin_in = 8'h31; m_pins = 8'h31;
    reg_addr = 2'd3; reg_wdata = 8'h00;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    rd(2'd3, v); check("R10 edge beats clear", v, 8'h01);
    m_flag = 8'h01;

    // random phase
    for (int k = 0; k < 60; k++) begin
      int op = $urandom_range(0, 3);
      if (op == 0) begin
        logic [N-1:0] p = N'($urandom);
        wr(2'd2, p); m_pol = p;
      end else if (op == 1) begin
        logic [N-1:0] c = N'($urandom);
        wr(2'd3, c); m_flag = m_flag & c;
      end else if (op == 2) begin
        logic [N-1:0] d = N'($urandom);
        wr(2'd1, d); m_dir = d;
        d = N'($urandom);
        wr(2'd0, d); m_data = d;
        rd(2'd0, v); check("R5 random data read", v, data_view(m_pins, m_dir, m_data));
        #1 check("R3 random oe", pin_oe, m_dir);
      end
      set_pins(N'($urandom));
      rd(2'd3, v); check("R8 random flags", v, m_flag);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule